// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower memory. It holds 64 lines of 16 bytes. Each line carries a tag, a valid flag and four 32-bit words. A 32-bit byte address selects exactly one line, so each memory block has only one place it can live. A read that finds its line present is accepted in the cycle it is presented. Its word comes back on the following cycle. A read that does not find its line holds the requester off while the full line is brought in from memory as four word beats. After the fill, the held request completes as a hit.

Every store is sent to memory through a four-entry posted write queue. The processor therefore waits on a store only when that queue is full. A store to a line that is present also merges its enabled bytes into the cached copy. For a store to a line that is absent, the `alloc_on_wmiss` input picks the action. In allocate mode the line is fetched first and the store then completes as a hit. In write-around mode the store goes only to memory and the cache is left unchanged. Before any line fetch, the write queue is emptied, so a fill can never return data that is older than a store already accepted.

Top module: `wt_dcache`

## Requirements
- R1: The address is split into a tag in bits 31..10, a line index in bits 9..4 and a byte offset in bits 3..0. Every line fetch presents the line base address on `mem_rd_addr`, with bits 3..0 zero.
- R2: The line index equals the block address (byte address / 16) modulo 64. Byte addresses 1200 and 2224 both use line 11, so each of them evicts the other.
- R3: After reset no line is valid, so the first read of any address causes a line fetch.
- R4: A read hits only when the indexed line is valid and its stored tag equals the address tag. On a hit, `cpu_req_ready` is high in the cycle the request is presented and no line fetch occurs.
- R5: On a read miss, `cpu_req_ready` stays low while one line fetch is made. The fill arrives as four beats, word 0 (offset 0) first. The held read then completes with the requested word.
- R6: A write hit merges the enabled bytes into the cached word (enable bit i selects data bits 8i+7..8i). The same address, data and enables are also sent to memory.
- R7: The write queue holds 4 entries. A write is accepted without stall while the queue is not full, and `cpu_req_ready` is low for a write while 4 entries are pending. Memory receives the queued writes in acceptance order, each with its own address, data and enables.
- R8: On a write miss with `alloc_on_wmiss`=1, the line is fetched before the write is accepted, and later reads of that line hit. With `alloc_on_wmiss`=0, no fetch is made, the write is accepted at once and the cache is unchanged, so a later read of that line misses.
- R9: While the write queue holds any entry, no line fetch request is raised.
- R10: `cpu_rsp_valid` pulses for exactly one cycle, in the cycle after each accepted read. It never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted on this edge when valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| alloc_on_wmiss | input | 1 | Write-miss policy: 1 allocate, 0 write-around |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Line fetch request |
| mem_rd_ready | input | 1 | Memory takes the fetch request |
| mem_rd_addr | output | 32 | Line base address of the fetch |
| mem_rd_beat_valid | input | 1 | Fill word present |
| mem_rd_beat_data | input | 32 | Fill word, lowest offset first |
| mem_wr_valid | output | 1 | Queued write present |
| mem_wr_ready | input | 1 | Memory takes the queued write |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Write byte enables |

## Verification
The following timings apply:
- A read or write that is accepted on one rising edge shows its effect right after that edge. A load response is valid in the next cycle.
- A hit shows `cpu_req_ready` high in the same cycle the request is driven.
- A miss holds `cpu_req_ready` low. It first waits for the write queue to empty. It then raises one fetch and needs four fill beats before the request is accepted.
- A queued write reaches memory in the first cycle that `mem_wr_ready` is high while it is at the head of the queue.

The bench drives all inputs at the falling edge. It samples ready one time unit later and samples every registered result at the falling edge after the accepting rising edge. It counts stall cycles rather than assuming them. Because the memory model raises its fill beats two cycles after taking the fetch, the stall counts it checks are non-zero only where a miss is expected.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_REQ   = 2'd2,
        ST_FILL  = 2'd3
    } fsm_e;

endpackage

// File: rtl/wt_dcache_lines.sv
module wt_dcache_lines #(
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WSEL_W-1:0] lk_wsel,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_word,
    // line fill
    input  logic              fill_we,
    input  logic              fill_last,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [WSEL_W-1:0] fill_wsel,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    // store merge
    input  logic              wr_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] wr_be
);
    localparam int NLINES = 1 << IDX_W;
    localparam int NWORDS = NLINES << WSEL_W;
    localparam int BE_W   = DATA_W / 8;

    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [DATA_W-1:0] data_q [NWORDS];
    logic [NLINES-1:0] valid_d, valid_q;
    logic [DATA_W-1:0] wr_merged;

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_word = data_q[{lk_idx, lk_wsel}];

    always_comb begin
        wr_merged = data_q[{wr_idx, wr_wsel}];
        for (int b = 0; b < BE_W; b++) begin
            if (wr_be[b]) wr_merged[8*b +: 8] = wr_data[8*b +: 8];
        end
    end

    always_comb begin
        valid_d = valid_q;
        if (fill_we && fill_last) valid_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            data_q[{fill_idx, fill_wsel}] <= fill_data;
            if (fill_last) tag_q[fill_idx] <= fill_tag;
        end else if (wr_we) begin
            data_q[{wr_idx, wr_wsel}] <= wr_merged;
        end
    end

    // R6: a store merge only targets a line that holds valid contents
    a_r6_merge_on_valid_line: assert property (@(posedge clk) disable iff (!rst_n)
        wr_we |-> valid_q[wr_idx]);

endmodule

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [DATA_W/8-1:0] in_be,
    output logic                full,
    output logic                empty,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [DATA_W-1:0]   out_data,
    output logic [DATA_W/8-1:0] out_be
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BE_W  = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } entry_t;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    entry_t slot_q [DEPTH];
    ptr_t   ptr_d, ptr_q;
    logic   pop;

    assign empty     = (ptr_q.cnt == '0);
    assign full      = (ptr_q.cnt == CNT_W'(DEPTH));
    assign out_valid = !empty;
    assign pop       = out_valid && out_ready;
    assign out_addr  = slot_q[ptr_q.rd_ptr].addr;
    assign out_data  = slot_q[ptr_q.rd_ptr].data;
    assign out_be    = slot_q[ptr_q.rd_ptr].be;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wr_ptr = step(ptr_q.wr_ptr);
        if (pop)  ptr_d.rd_ptr = step(ptr_q.rd_ptr);
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[ptr_q.wr_ptr] <= '{addr: in_addr, data: in_data, be: in_be};
    end

    // R7: the controller never pushes into a full queue
    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: a head entry not yet taken by memory stays put
    a_r7_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_data) && $stable(out_be)));

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 16,
    parameter int WB_DEPTH   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req_valid,
    output logic                cpu_req_ready,
    input  logic                cpu_req_write,
    input  logic [ADDR_W-1:0]   cpu_req_addr,
    input  logic [DATA_W-1:0]   cpu_req_wdata,
    input  logic [DATA_W/8-1:0] cpu_req_be,
    input  logic                alloc_on_wmiss,
    output logic                cpu_rsp_valid,
    output logic [DATA_W-1:0]   cpu_rsp_rdata,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_beat_valid,
    input  logic [DATA_W-1:0]   mem_rd_beat_data,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    output logic [DATA_W/8-1:0] mem_wr_be
);
    localparam int BE_W   = DATA_W / 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WPL    = LINE_BYTES / BE_W;
    localparam int WSEL_W = $clog2(WPL);
    localparam int BSEL_W = $clog2(BE_W);

    typedef struct packed {
        fsm_e              st;
        logic [WSEL_W-1:0] beat;
        logic [ADDR_W-1:0] line_addr;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_word;
    logic              wb_full, wb_empty, wb_push;
    logic              accept, go_miss, fill_we, fill_last;

    assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_req_addr[OFF_W +: IDX_W];
    assign req_wsel = cpu_req_addr[BSEL_W +: WSEL_W];

    // ready: reads need a hit, writes need queue room and either a hit or write-around
    assign cpu_req_ready = (ctl_q.st == ST_IDLE) &&
        (cpu_req_write ? (!wb_full && (lk_hit || !alloc_on_wmiss)) : lk_hit);
    assign accept  = cpu_req_valid && cpu_req_ready;
    assign go_miss = (ctl_q.st == ST_IDLE) && cpu_req_valid && !lk_hit &&
                     (!cpu_req_write || alloc_on_wmiss);
    assign wb_push = accept && cpu_req_write;

    assign fill_we   = (ctl_q.st == ST_FILL) && mem_rd_beat_valid;
    assign fill_last = (ctl_q.beat == WSEL_W'(WPL - 1));

    assign mem_rd_valid  = (ctl_q.st == ST_REQ);
    assign mem_rd_addr   = ctl_q.line_addr;
    assign cpu_rsp_valid = ctl_q.rsp_v;
    assign cpu_rsp_rdata = ctl_q.rsp_d;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = accept && !cpu_req_write;
        if (accept && !cpu_req_write) ctl_d.rsp_d = lk_word;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (go_miss) begin
                    ctl_d.st        = ST_DRAIN;
                    ctl_d.line_addr = {cpu_req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                end
            end
            ST_DRAIN: begin
                if (wb_empty) ctl_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (mem_rd_ready) begin
                    ctl_d.st   = ST_FILL;
                    ctl_d.beat = '0;
                end
            end
            ST_FILL: begin
                if (mem_rd_beat_valid) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (fill_last) ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    wt_dcache_lines #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .WSEL_W(WSEL_W),
        .DATA_W(DATA_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_idx),
        .lk_tag   (req_tag),
        .lk_wsel  (req_wsel),
        .lk_hit   (lk_hit),
        .lk_word  (lk_word),
        .fill_we  (fill_we),
        .fill_last(fill_last),
        .fill_idx (ctl_q.line_addr[OFF_W +: IDX_W]),
        .fill_wsel(ctl_q.beat),
        .fill_tag (ctl_q.line_addr[ADDR_W-1 -: TAG_W]),
        .fill_data(mem_rd_beat_data),
        .wr_we    (wb_push && lk_hit),
        .wr_idx   (req_idx),
        .wr_wsel  (req_wsel),
        .wr_data  (cpu_req_wdata),
        .wr_be    (cpu_req_be)
    );

    wt_dcache_wbuf #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEPTH (WB_DEPTH)
    ) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wb_push),
        .in_addr  (cpu_req_addr),
        .in_data  (cpu_req_wdata),
        .in_be    (cpu_req_be),
        .full     (wb_full),
        .empty    (wb_empty),
        .out_valid(mem_wr_valid),
        .out_ready(mem_wr_ready),
        .out_addr (mem_wr_addr),
        .out_data (mem_wr_data),
        .out_be   (mem_wr_be)
    );

    // R9: no line fetch while stores are still queued
    a_r9_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> wb_empty);

    // R10: a response follows an accepted read by one cycle
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready && !cpu_req_write));

    // R5: fill beats only arrive while a fill is in progress
    a_r5_beats_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_beat_valid |-> (ctl_q.st == ST_FILL));

    // R1: fetch address is line aligned
    a_r1_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[OFF_W-1:0] == '0));

endmodule

// File: tb/test_wt_dcache.sv
module test_wt_dcache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, alloc = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        cpu_req_ready, cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_rd_valid, mem_wr_valid;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic        wr_hold = 1'b0;

    int n_chk = 0, n_fail = 0, rd_cnt = 0, wlog_n = 0;
    logic [31:0] last_rd;
    logic [31:0] mem_model [4096];
    logic [31:0] ref_mem   [4096];
    logic [31:0] wl_addr [64];
    logic [31:0] wl_data [64];
    logic [3:0]  wl_be   [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_dcache i_wt_dcache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(req_write), .cpu_req_addr(req_addr),
        .cpu_req_wdata(req_wdata), .cpu_req_be(req_be),
        .alloc_on_wmiss(alloc),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(1'b1), .mem_rd_addr(mem_rd_addr),
        .mem_rd_beat_valid(beat_valid), .mem_rd_beat_data(beat_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(!wr_hold),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    function automatic logic [11:0] widx(input logic [31:0] a);
        return a[13:2];
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory: fill responder (fetch taken at once, beats two cycles later)
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                rd_cnt++;
                last_rd = mem_rd_addr;
                @(negedge clk);
                @(negedge clk);
                for (int w = 0; w < 4; w++) begin
                    beat_valid = 1'b1;
                    beat_data  = mem_model[widx(last_rd + 32'(4*w))];
                    @(negedge clk);
                end
                beat_valid = 1'b0;
            end
        end
    end

    // memory: write monitor (handshake completes on the coming rising edge)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mem_wr_valid && !wr_hold) begin
                mem_model[widx(mem_wr_addr)] = merge(mem_model[widx(mem_wr_addr)],
                                                     mem_wr_data, mem_wr_be);
                if (wlog_n < 64) begin
                    wl_addr[wlog_n] = mem_wr_addr;
                    wl_data[wlog_n] = mem_wr_data;
                    wl_be[wlog_n]   = mem_wr_be;
                end
                wlog_n++;
            end
        end
    end

    task automatic cpu_read(input logic [31:0] a, output logic [31:0] d, output int stall);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1; stall = 0;
        while (!cpu_req_ready && stall < 500) begin
            @(negedge clk); #1; stall++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        d = cpu_rsp_rdata;
        chk(cpu_rsp_valid, "R10 rsp after read", 32'(cpu_rsp_valid), 1);
        @(negedge clk);
        chk(!cpu_rsp_valid, "R10 single rsp pulse", 32'(cpu_rsp_valid), 0);
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] be, output int stall);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        #1; stall = 0;
        while (!cpu_req_ready && stall < 500) begin
            @(negedge clk); #1; stall++;
        end
        ref_mem[widx(a)] = merge(ref_mem[widx(a)], d, be);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(!cpu_rsp_valid, "R10 no rsp for write", 32'(cpu_rsp_valid), 0);
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 50 && mem_wr_valid; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(!cpu_rsp_valid && !mem_rd_valid && !mem_wr_valid, "R3 idle outputs after reset",
            {29'd0, cpu_rsp_valid, mem_rd_valid, mem_wr_valid}, 0);
    endtask

    task automatic t_read_miss();
        logic [31:0] d; int s; int r0 = rd_cnt;
        cpu_read(32'd1208, d, s);
        chk(s > 0, "R3 cold read stalls", 32'(s), 1);
        chk(rd_cnt == r0 + 1, "R5 one fetch on read miss", 32'(rd_cnt - r0), 1);
        chk(last_rd == 32'd1200, "R1 fetch at line base", last_rd, 32'd1200);
        chk(d == ref_mem[widx(1208)], "R5 read miss data", d, ref_mem[widx(1208)]);
    endtask

    task automatic t_read_hit();
        logic [31:0] d; int s; int r0 = rd_cnt;
        cpu_read(32'd1200, d, s);
        chk(s == 0, "R4 hit no stall", 32'(s), 0);
        chk(d == ref_mem[widx(1200)], "R4 hit word 0", d, ref_mem[widx(1200)]);
        cpu_read(32'd1212, d, s);
        chk(d == ref_mem[widx(1212)], "R4 hit word 3", d, ref_mem[widx(1212)]);
        chk(rd_cnt == r0, "R4 no fetch on hit", 32'(rd_cnt - r0), 0);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int s; int r0 = rd_cnt;
        cpu_read(32'd2224, d, s);
        chk(last_rd == 32'd2224 && rd_cnt == r0 + 1, "R2 same index other tag misses",
            last_rd, 32'd2224);
        chk(d == ref_mem[widx(2224)], "R2 conflict data", d, ref_mem[widx(2224)]);
        cpu_read(32'd1200, d, s);
        chk(rd_cnt == r0 + 2, "R2 evicted line refetched", 32'(rd_cnt - r0), 2);
        chk(d == ref_mem[widx(1200)], "R2 refetch data", d, ref_mem[widx(1200)]);
    endtask

    task automatic t_write_hit();
        logic [31:0] d; int s; int r0 = rd_cnt; int w0 = wlog_n;
        cpu_write(32'd1204, 32'h11223344, 4'b0101, s);
        chk(s == 0, "R6 write hit no stall", 32'(s), 0);
        wait_drain();
        chk(wlog_n == w0 + 1 && wl_addr[w0] == 32'd1204 && wl_data[w0] == 32'h11223344
            && wl_be[w0] == 4'b0101, "R6 write hit sent to memory", wl_data[w0], 32'h11223344);
        cpu_read(32'd1204, d, s);
        chk(rd_cnt == r0, "R6 read after write hit no fetch", 32'(rd_cnt - r0), 0);
        chk(d == ref_mem[widx(1204)], "R6 merged bytes", d, ref_mem[widx(1204)]);
    endtask

    task automatic t_write_around();
        logic [31:0] d; int s; int r0 = rd_cnt;
        alloc = 1'b0;
        cpu_write(32'd3000, 32'hCAFEF00D, 4'b1111, s);
        chk(s == 0 && rd_cnt == r0, "R8 write-around no fetch", 32'(rd_cnt - r0), 0);
        wait_drain();
        cpu_read(32'd3000, d, s);
        chk(rd_cnt == r0 + 1, "R8 write-around left line absent", 32'(rd_cnt - r0), 1);
        chk(d == 32'hCAFEF00D, "R8 write-around data in memory", d, 32'hCAFEF00D);
    endtask

    task automatic t_write_alloc();
        logic [31:0] d; int s; int r0 = rd_cnt;
        alloc = 1'b1;
        cpu_write(32'd4000, 32'h0BADBEEF, 4'b1111, s);
        chk(s > 0 && rd_cnt == r0 + 1, "R8 allocate fetches first", 32'(rd_cnt - r0), 1);
        wait_drain();
        cpu_read(32'd4000, d, s);
        chk(rd_cnt == r0 + 1 && s == 0, "R8 allocated line hits", 32'(s), 0);
        chk(d == 32'h0BADBEEF, "R8 allocated data", d, 32'h0BADBEEF);
        alloc = 1'b0;
    endtask

    task automatic t_buffer_full();
        int s; int w0 = wlog_n; bit held = 1'b1;
        logic [31:0] a [5] = '{32'h100, 32'h104, 32'h300, 32'h2000, 32'h2004};
        wr_hold = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cpu_write(a[i], 32'hA0000000 + 32'(i), 4'(i + 1), s);
            chk(s == 0, "R7 queued write no stall", 32'(s), 0);
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a[4];
        req_wdata = 32'hA0000004; req_be = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            #1; if (cpu_req_ready) held = 1'b0;
            @(negedge clk);
        end
        chk(held, "R7 stall while full", 32'(held), 1);
        wr_hold = 1'b0;
        #1;
        for (int k = 0; k < 20 && !cpu_req_ready; k++) begin @(negedge clk); #1; end
        ref_mem[widx(a[4])] = 32'hA0000004;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        wait_drain();
        chk(wlog_n == w0 + 5, "R7 all writes reach memory", 32'(wlog_n - w0), 5);
        for (int i = 0; i < 5; i++)
            chk(wl_addr[w0+i] == a[i] && wl_data[w0+i] == 32'hA0000000 + 32'(i),
                "R7 write order", wl_addr[w0+i], a[i]);
    endtask

    task automatic t_read_waits_drain();
        logic [31:0] d; int s; bit quiet = 1'b1;
        wr_hold = 1'b1;
        cpu_write(32'h600, 32'h5EED1234, 4'b1111, s);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h600;
        for (int k = 0; k < 4; k++) begin
            #1; if (mem_rd_valid || cpu_req_ready) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R9 no fetch while queue holds entries", 32'(quiet), 1);
        wr_hold = 1'b0;
        #1;
        for (int k = 0; k < 50 && !cpu_req_ready; k++) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        d = cpu_rsp_rdata;
        chk(cpu_rsp_valid && d == 32'h5EED1234, "R9 fill sees drained store", d, 32'h5EED1234);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem_model[i] = 32'h3C000000 + 32'(i) * 32'h00010003;
            ref_mem[i]   = mem_model[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_conflict();
        t_write_hit();
        t_write_around();
        t_write_alloc();
        t_buffer_full();
        t_read_waits_drain();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule